// File: doc/BRIEF.md
# Replication-Aware Victim Selector

This block manages the replacement state of one set in a private second-level cache whose capacity is lent to neighbouring caches. For each way it keeps a valid flag, an LRU age rank, a flag that marks the block as the only copy on the chip, and a small counter of how many more times the block may move to another cache. When the cache controller asks for a victim, the block chooses the way to free. It then decides what happens to the evicted block: discard it, offer it to a neighbour, or write it to memory.

Victim choice follows a fixed priority. Empty ways come first. Next come blocks that still have a copy elsewhere on the chip, because losing them costs no off-chip access. Sole on-chip copies are chosen only when nothing else is left. Within each class the oldest block goes. A sole copy may be offered to a neighbour only a limited number of times before it leaves the chip. This stops an unused block from moving between caches without end. Any hit on the block restores its full allowance.

The controller drives one operation per cycle: fill a way, access a way, update a way's sole-copy flag, or request an eviction. The eviction result appears on registered outputs one cycle later.

Top module: `vsel_victim_sel`

## Requirements
- R1: On an eviction request, if any way is invalid, the lowest-numbered invalid way is returned with disposition 2'b11 (empty) and count 0.
- R2: When no way is invalid, a valid replicate (sole-copy flag 0) is chosen in preference to every singlet (sole-copy flag 1) in the set.
- R3: When no way is invalid and several replicates are valid, the replicate with the largest age (least recently used) is chosen.
- R4: When all ways are valid singlets, the way with the largest age is chosen.
- R5: A fill of any way, or an access to a valid way, gives that way age 0. Every way that was younger than it ages by one, and all other ages stay unchanged. The ages always form a permutation of 0 to WAYS-1.
- R6: An evicted replicate gets disposition 2'b00 (drop) and count 0.
- R7: An evicted singlet whose counter is 0 (never spilled since its last access or fill) gets disposition 2'b01 (spill), and the outgoing count is loaded with RECIRC_N (default 1). If RECIRC_N is 0, it gets 2'b10 instead.
- R8: An evicted singlet whose counter is 1 gets disposition 2'b10 (write to memory) with count 0. A counter above 1 gives 2'b01 (spill) with the count decremented by one.
- R9: An access to a valid way clears its counter. An access or a flag update aimed at an invalid way has no effect.
- R10: The result (rsp_vld high with way, disposition and count) appears exactly one cycle after an eviction request, and only then. The chosen way becomes invalid at that same edge.
- R11: After reset, all ways are invalid, way i has age i, all counters are 0, and rsp_vld is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | Operation strobe |
| op_code | input | 2 | 0 access, 1 fill, 2 evict, 3 update sole-copy flag |
| op_way | input | WAY_W | Target way for access, fill and flag update |
| op_singlet | input | 1 | Sole-copy flag for fill and flag update |
| op_cnt | input | CNT_W | Counter value installed by a fill (nonzero for a spilled-in block) |
| rsp_vld | output | 1 | Eviction result valid |
| rsp_way | output | WAY_W | Chosen victim way |
| rsp_disp | output | 2 | 00 drop, 01 spill, 10 write to memory, 11 empty |
| rsp_cnt | output | CNT_W | Counter value that travels with a spilled block |

## Verification
The checks assume that the controller issues at most one operation per cycle and fills a way only with an installed count below 2**CNT_W. The spill check also assumes the installed count is consistent with RECIRC_N. The stimulus keeps to these limits: it drives exactly one encoded operation per cycle from a seeded random mix. It draws fill counts from the counter's legal range and aims accesses and flag updates at valid and invalid ways alike. Directed sequences place a chosen way at the LRU end before eviction, so that counter reset, the spill limit and the replicate-first rule are each hit on purpose.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    typedef enum logic [1:0] {
        OP_ACCESS = 2'd0,
        OP_FILL   = 2'd1,
        OP_EVICT  = 2'd2,
        OP_MARK   = 2'd3
    } vsel_op_e;

    typedef enum logic [1:0] {
        DISP_DROP  = 2'b00,
        DISP_SPILL = 2'b01,
        DISP_MEMWB = 2'b10,
        DISP_EMPTY = 2'b11
    } vsel_disp_e;

    function automatic logic op_is(input logic vld, input logic [1:0] code, input vsel_op_e kind);
        return vld && (vsel_op_e'(code) == kind);
    endfunction

endpackage

// File: rtl/vsel_age_track.sv
module vsel_age_track #(
    parameter int WAYS  = 8,
    parameter int AGE_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        touch_vld,
    input  logic [AGE_W-1:0]            touch_way,
    output logic [WAYS-1:0][AGE_W-1:0]  ages
);

    logic [AGE_W-1:0] touched_age;
    assign touched_age = ages[touch_way];

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [AGE_W-1:0] age_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                age_q <= AGE_W'(g);
            end else if (touch_vld) begin
                if (touch_way == AGE_W'(g)) begin
                    age_q <= '0;
                end else if (age_q < touched_age) begin
                    age_q <= age_q + 1'b1;
                end
            end
        end

        assign ages[g] = age_q;
    end

endmodule

// File: rtl/vsel_way_state.sv
module vsel_way_state #(
    parameter int WAYS  = 8,
    parameter int CNT_W = 2,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        do_fill,
    input  logic                        do_access,
    input  logic                        do_mark,
    input  logic                        do_evict,
    input  logic [WAY_W-1:0]            op_way,
    input  logic                        op_singlet,
    input  logic [CNT_W-1:0]            op_cnt,
    input  logic [WAY_W-1:0]            vict_way,
    input  logic [CNT_W-1:0]            vict_cnt,
    output logic [WAYS-1:0]             valid,
    output logic [WAYS-1:0]             singlet,
    output logic [WAYS-1:0][CNT_W-1:0]  cnt
);

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic             v_q;
        logic             s_q;
        logic [CNT_W-1:0] c_q;
        logic             hit_op;
        logic             hit_ev;

        assign hit_op = (op_way == WAY_W'(g));
        assign hit_ev = do_evict && (vict_way == WAY_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                s_q <= 1'b0;
                c_q <= '0;
            end else if (hit_ev) begin
                v_q <= 1'b0;
                c_q <= vict_cnt;
            end else if (hit_op) begin
                if (do_fill) begin
                    v_q <= 1'b1;
                    s_q <= op_singlet;
                    c_q <= op_cnt;
                end else if (do_access && v_q) begin
                    c_q <= '0;
                end else if (do_mark && v_q) begin
                    s_q <= op_singlet;
                end
            end
        end

        assign valid[g]   = v_q;
        assign singlet[g] = s_q;
        assign cnt[g]     = c_q;
    end

endmodule

// File: rtl/vsel_pick.sv
module vsel_pick #(
    parameter int WAYS  = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0]             singlet,
    input  logic [WAYS-1:0][WAY_W-1:0]  ages,
    output logic [WAY_W-1:0]            vict_way,
    output logic                        vict_empty,
    output logic                        vict_singlet
);

    logic             found_inv, found_rep, found_any;
    logic [WAY_W-1:0] inv_w, rep_w, any_w;
    logic [WAY_W-1:0] rep_a, any_a;

    always_comb begin
        found_inv = 1'b0;
        inv_w     = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                found_inv = 1'b1;
                inv_w     = WAY_W'(i);
            end
        end
    end

    always_comb begin
        found_rep = 1'b0;
        found_any = 1'b0;
        rep_w     = '0;
        any_w     = '0;
        rep_a     = '0;
        any_a     = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (valid[i]) begin
                if (!found_any || ages[i] > any_a) begin
                    found_any = 1'b1;
                    any_w     = WAY_W'(i);
                    any_a     = ages[i];
                end
                if (!singlet[i] && (!found_rep || ages[i] > rep_a)) begin
                    found_rep = 1'b1;
                    rep_w     = WAY_W'(i);
                    rep_a     = ages[i];
                end
            end
        end
    end

    always_comb begin
        vict_empty   = found_inv;
        vict_singlet = !found_inv && !found_rep && found_any;
        if (found_inv) begin
            vict_way = inv_w;
        end else if (found_rep) begin
            vict_way = rep_w;
        end else begin
            vict_way = any_w;
        end
    end

endmodule

// File: rtl/vsel_disp.sv
module vsel_disp
    import vsel_pkg::*;
#(
    parameter int CNT_W    = 2,
    parameter int RECIRC_N = 1
) (
    input  logic              empty,
    input  logic              singlet,
    input  logic [CNT_W-1:0]  cnt_in,
    output vsel_disp_e        disp,
    output logic [CNT_W-1:0]  cnt_out
);

    localparam logic [CNT_W-1:0] LOAD_N = CNT_W'(RECIRC_N);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    always_comb begin
        disp    = DISP_EMPTY;
        cnt_out = '0;
        if (empty) begin
            disp = DISP_EMPTY;
        end else if (!singlet) begin
            disp = DISP_DROP;
        end else if (cnt_in == '0) begin
            if (LOAD_N == '0) begin
                disp = DISP_MEMWB;
            end else begin
                disp    = DISP_SPILL;
                cnt_out = LOAD_N;
            end
        end else if (cnt_in == ONE) begin
            disp = DISP_MEMWB;
        end else begin
            disp    = DISP_SPILL;
            cnt_out = cnt_in - ONE;
        end
    end

endmodule

// File: rtl/vsel_victim_sel.sv
module vsel_victim_sel
    import vsel_pkg::*;
#(
    parameter int WAYS     = 8,
    parameter int CNT_W    = 2,
    parameter int RECIRC_N = 1,
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_vld,
    input  logic [1:0]        op_code,
    input  logic [WAY_W-1:0]  op_way,
    input  logic              op_singlet,
    input  logic [CNT_W-1:0]  op_cnt,
    output logic              rsp_vld,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [1:0]        rsp_disp,
    output logic [CNT_W-1:0]  rsp_cnt
);

    logic do_fill, do_access, do_mark, do_evict, touch;
    logic [WAYS-1:0]            valid_q;
    logic [WAYS-1:0]            singlet_q;
    logic [WAYS-1:0][CNT_W-1:0] cnt_q;
    logic [WAYS-1:0][WAY_W-1:0] age_q;
    logic [WAY_W-1:0]           vict_way;
    logic                       vict_empty, vict_singlet;
    vsel_disp_e                 vict_disp;
    logic [CNT_W-1:0]           vict_cnt;

    assign do_fill   = op_is(op_vld, op_code, OP_FILL);
    assign do_access = op_is(op_vld, op_code, OP_ACCESS);
    assign do_mark   = op_is(op_vld, op_code, OP_MARK);
    assign do_evict  = op_is(op_vld, op_code, OP_EVICT);
    assign touch     = do_fill || (do_access && valid_q[op_way]);

    vsel_age_track #(.WAYS(WAYS), .AGE_W(WAY_W)) u_age (
        .clk       (clk),
        .rst       (rst),
        .touch_vld (touch),
        .touch_way (op_way),
        .ages      (age_q)
    );

    vsel_way_state #(.WAYS(WAYS), .CNT_W(CNT_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .do_fill    (do_fill),
        .do_access  (do_access),
        .do_mark    (do_mark),
        .do_evict   (do_evict),
        .op_way     (op_way),
        .op_singlet (op_singlet),
        .op_cnt     (op_cnt),
        .vict_way   (vict_way),
        .vict_cnt   (vict_cnt),
        .valid      (valid_q),
        .singlet    (singlet_q),
        .cnt        (cnt_q)
    );

    vsel_pick #(.WAYS(WAYS)) u_pick (
        .valid        (valid_q),
        .singlet      (singlet_q),
        .ages         (age_q),
        .vict_way     (vict_way),
        .vict_empty   (vict_empty),
        .vict_singlet (vict_singlet)
    );

    vsel_disp #(.CNT_W(CNT_W), .RECIRC_N(RECIRC_N)) u_disp (
        .empty   (vict_empty),
        .singlet (vict_singlet),
        .cnt_in  (cnt_q[vict_way]),
        .disp    (vict_disp),
        .cnt_out (vict_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld  <= 1'b0;
            rsp_way  <= '0;
            rsp_disp <= DISP_EMPTY;
            rsp_cnt  <= '0;
        end else begin
            rsp_vld <= do_evict;
            if (do_evict) begin
                rsp_way  <= vict_way;
                rsp_disp <= vict_disp;
                rsp_cnt  <= vict_cnt;
            end
        end
    end

endmodule

// File: rtl/vsel_victim_sel_chk.sv
module vsel_victim_sel_chk #(
    parameter int WAYS     = 8,
    parameter int CNT_W    = 2,
    parameter int RECIRC_N = 1,
    localparam int WAY_W   = $clog2(WAYS)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        op_vld,
    input logic [1:0]                  op_code,
    input logic                        rsp_vld,
    input logic [WAY_W-1:0]            rsp_way,
    input logic [1:0]                  rsp_disp,
    input logic [CNT_W-1:0]            rsp_cnt,
    input logic [WAYS-1:0]             valid_q,
    input logic [WAYS-1:0][WAY_W-1:0]  age_q
);

    logic [WAYS-1:0] seen_age;
    logic            ev_req;

    always_comb begin
        seen_age = '0;
        for (int i = 0; i < WAYS; i++) begin
            seen_age[age_q[i]] = 1'b1;
        end
    end

    assign ev_req = op_vld && (op_code == 2'd2);

    // R10
    evict_rsp_next_chk: assert property (@(posedge clk) disable iff (rst)
        ev_req |=> rsp_vld);

    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !ev_req |=> !rsp_vld);

    // R10
    victim_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> !valid_q[rsp_way]);

    // R6
    zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_disp != 2'b01) |-> (rsp_cnt == '0));

    // R7
    spill_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_disp == 2'b01) |-> (rsp_cnt != '0));

    // R5
    age_perm_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(seen_age) == WAYS);

endmodule

bind vsel_victim_sel vsel_victim_sel_chk #(
    .WAYS(WAYS), .CNT_W(CNT_W), .RECIRC_N(RECIRC_N)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_vld   (op_vld),
    .op_code  (op_code),
    .rsp_vld  (rsp_vld),
    .rsp_way  (rsp_way),
    .rsp_disp (rsp_disp),
    .rsp_cnt  (rsp_cnt),
    .valid_q  (valid_q),
    .age_q    (age_q)
);

// File: tb/tb_vsel_victim_sel.sv
`timescale 1ns/1ps
module tb_vsel_victim_sel;

    localparam int WAYS  = 8;
    localparam int CNT_W = 2;
    localparam int NLOAD = 1;
    localparam int WAY_W = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             op_vld;
    logic [1:0]       op_code;
    logic [WAY_W-1:0] op_way;
    logic             op_singlet;
    logic [CNT_W-1:0] op_cnt;
    logic             rsp_vld;
    logic [WAY_W-1:0] rsp_way;
    logic [1:0]       rsp_disp;
    logic [CNT_W-1:0] rsp_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int m_valid [WAYS];
    int m_sng   [WAYS];
    int m_cnt   [WAYS];
    int m_age   [WAYS];
    string force_tag = "";

    always #2.5 clk = ~clk;

    vsel_victim_sel #(.WAYS(WAYS), .CNT_W(CNT_W), .RECIRC_N(NLOAD)) dut (
        .clk(clk), .rst(rst), .op_vld(op_vld), .op_code(op_code),
        .op_way(op_way), .op_singlet(op_singlet), .op_cnt(op_cnt),
        .rsp_vld(rsp_vld), .rsp_way(rsp_way), .rsp_disp(rsp_disp), .rsp_cnt(rsp_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic m_touch(input int w);
        int a = m_age[w];
        for (int i = 0; i < WAYS; i++) if (m_age[i] < a) m_age[i]++;
        m_age[w] = 0;
    endtask

    task automatic do_op(input int code, input int way, input int sg, input int cnt);
        int ew = -1, ed = 3, ec = 0;
        string wt = "R1", dt = "R1";
        if (code == 2) begin
            for (int i = 0; i < WAYS; i++) if (!m_valid[i] && ew < 0) ew = i;
            if (ew < 0) begin
                int any_sng = 0;
                for (int i = 0; i < WAYS; i++) begin
                    if (m_sng[i]) any_sng = 1;
                    if (!m_sng[i] && (ew < 0 || m_age[i] > m_age[ew])) ew = i;
                end
                if (ew >= 0) begin
                    wt = any_sng ? "R2" : "R3";
                    ed = 0; ec = 0; dt = "R6";
                end else begin
                    for (int i = 0; i < WAYS; i++) if (ew < 0 || m_age[i] > m_age[ew]) ew = i;
                    wt = "R4";
                    if (m_cnt[ew] == 0) begin
                        dt = "R7";
                        if (NLOAD == 0) begin ed = 2; ec = 0; end
                        else begin ed = 1; ec = NLOAD; end
                    end else if (m_cnt[ew] == 1) begin
                        dt = "R8"; ed = 2; ec = 0;
                    end else begin
                        dt = "R8"; ed = 1; ec = m_cnt[ew] - 1;
                    end
                end
            end
            if (force_tag != "") wt = force_tag;
            m_valid[ew] = 0;
            m_cnt[ew]   = ec;
        end else if (code == 1) begin
            m_valid[way] = 1; m_sng[way] = sg; m_cnt[way] = cnt; m_touch(way);
        end else if (code == 0) begin
            if (m_valid[way]) begin m_cnt[way] = 0; m_touch(way); end
        end else begin
            if (m_valid[way]) m_sng[way] = sg;
        end
        op_vld = 1'b1; op_code = 2'(code); op_way = 3'(way);
        op_singlet = 1'(sg); op_cnt = 2'(cnt);
        @(negedge clk);
        op_vld = 1'b0;
        if (code == 2) begin
            chk("R10 rsp_vld", int'(rsp_vld), 1);
            chk({wt, " way"}, int'(rsp_way), ew);
            chk({dt, " disp"}, int'(rsp_disp), ed);
            chk({dt, " cnt"}, int'(rsp_cnt), ec);
        end else begin
            chk("R10 no rsp", int'(rsp_vld), 0);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; op_vld = 0; op_code = 0; op_way = 0; op_singlet = 0; op_cnt = 0;
        for (int i = 0; i < WAYS; i++) begin
            m_valid[i] = 0; m_sng[i] = 0; m_cnt[i] = 0; m_age[i] = i;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset rsp_vld", int'(rsp_vld), 0);

        force_tag = "R11";
        do_op(2, 0, 0, 0);
        force_tag = "";

        for (int i = 0; i < WAYS; i++) do_op(1, i, 1, 0);
        do_op(0, 0, 0, 0);
        force_tag = "R5"; do_op(2, 0, 0, 0); force_tag = "";
        do_op(3, 5, 0, 0);
        force_tag = "R2"; do_op(2, 0, 0, 0); force_tag = "";
        force_tag = "R1"; do_op(2, 0, 0, 0); force_tag = "";

        do_op(1, 5, 1, 0);
        do_op(1, 1, 1, 1);
        do_op(0, 1, 0, 0);
        for (int i = 0; i < WAYS; i++) if (i != 1) do_op(0, i, 0, 0);
        force_tag = "R9"; do_op(2, 0, 0, 0); force_tag = "";

        do_op(1, 1, 1, 1);
        for (int i = 0; i < WAYS; i++) if (i != 1) do_op(0, i, 0, 0);
        do_op(2, 0, 0, 0);

        do_op(1, 1, 1, 3);
        for (int i = 0; i < WAYS; i++) if (i != 1) do_op(0, i, 0, 0);
        do_op(2, 0, 0, 0);

        do_op(0, 1, 0, 0);
        do_op(3, 1, 0, 0);
        force_tag = "R9"; do_op(2, 0, 0, 0); force_tag = "";

        for (int n = 0; n < 4000; n++) begin
            int r = $urandom % 100;
            int w = $urandom % WAYS;
            int s = ($urandom % 3 == 0) ? 0 : 1;
            int c = $urandom % 4;
            if (r < 35)      do_op(1, w, s, c);
            else if (r < 65) do_op(0, w, 0, 0);
            else if (r < 90) do_op(2, 0, 0, 0);
            else             do_op(3, w, s, 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule